// File: doc/BRIEF.md
# Interrupt highest-priority resolver

This block takes the state of an interrupt controller, which is two 32-bit banks each of pending, mask and steering bits, together with a table of 40 programmable priority slots. It reduces them to one 32-bit highest-priority word. Each slot names a source. The slot's position in the table sets its rank, so software orders the sources by rewriting the table. Fixed source numbering has no part in the ordering.

The word carries two results side by side. The low half names the winning source steered to the fast interrupt. The high half names the winning source steered to the normal interrupt. Each half has its own valid flag. A half with no winner reads the sentinel ID 63 with its flag clear.

The default build registers the word, so it follows the inputs with one cycle of latency. A parameter removes the register for a purely combinational result. A second parameter selects how the lowest active slot is picked.

Top module: `irq_hp_resolver`

## Requirements
- R1: A table slot is 32 bits wide. Bit 31 is its enable and bits 5:0 are its source ID. A slot takes part only when bit 31 is set and the ID is below 40. All its other bits are ignored.
- R2: A source is active when its pending bit and its mask bit are both set in its bank. IDs 0 to 31 use bank 0 at bit ID. IDs 32 to 39 use bank 1 at bit ID minus 32.
- R3: Among the slots whose source is active and steered to the same field, the slot with the smallest index wins. The same ID may appear in several slots.
- R4: An active source whose steering bit is set competes only for the fast field, which is the low half of the word.
- R5: An active source whose steering bit is clear competes only for the normal field, which is the high half of the word.
- R6: In the fast field, bit 15 is the valid flag and bits 5:0 hold the winning ID.
- R7: In the normal field, bit 31 is the valid flag and bits 21:16 hold the winning ID.
- R8: A field with no winner has its valid flag clear and its ID bits equal to 63. With no winner in either field the word is 0x003F003F.
- R9: Bits 30:22 and 14:6 of the word always read zero.
- R10: In the registered build, the word reflects the inputs sampled at the previous rising clock edge. It does not change between edges. While reset is low it reads 0x003F003F.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for the output register |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pend_b0_i | input | 32 | Pending bits of sources 0 to 31 |
| pend_b1_i | input | 32 | Pending bits of sources 32 and up |
| mask_b0_i | input | 32 | Mask (enable) bits of bank 0 |
| mask_b1_i | input | 32 | Mask (enable) bits of bank 1 |
| steer_b0_i | input | 32 | Steering bits of bank 0, set for fast |
| steer_b1_i | input | 32 | Steering bits of bank 1, set for fast |
| prio_tab_i | input | 1280 | 40 packed table slots, slot k at bits 32k+31:32k |
| hp_word_o | output | 32 | Encoded highest-priority word |

## Verification
The checker watches four properties on every cycle. Reserved bits stay zero. An empty field holds the sentinel. Any valid winner in a field is a source that was active and steered to that field at the previous edge. No winner appears when no source of that steering was active.

Only the bench scenarios can show that the chosen winner comes from the lowest matching slot. The same goes for disabled and out-of-range slots being skipped, the bank split at ID 32, and the output holding still between edges. The bench compares every cycle against a behavioural model that walks the table.

// File: rtl/irq_hp_pkg.sv
package irq_hp_pkg;

   // Output word layout, fixed by the consumer of the word
   localparam int HP_ID_W        = 6;
   localparam int HP_WORD_W      = 32;
   localparam int HP_FAST_VLD    = 15;
   localparam int HP_NORM_VLD    = 31;
   localparam int HP_NORM_ID_LSB = 16;
   localparam logic [HP_ID_W-1:0] HP_NONE_ID = '1;

   typedef struct packed {
      logic               vld;
      logic [HP_ID_W-1:0] id;
   } hp_win_t;

   // Builds the word from the two winners; an empty field carries the sentinel ID
   function automatic logic [HP_WORD_W-1:0] hp_pack(hp_win_t fast, hp_win_t norm);
      logic [HP_WORD_W-1:0] w;
      w = '0;
      w[HP_FAST_VLD] = fast.vld;
      w[HP_ID_W-1:0] = fast.vld ? fast.id : HP_NONE_ID;
      w[HP_NORM_VLD] = norm.vld;
      w[HP_NORM_ID_LSB +: HP_ID_W] = norm.vld ? norm.id : HP_NONE_ID;
      return w;
   endfunction

   localparam logic [HP_WORD_W-1:0] HP_IDLE_WORD = 32'h003F_003F;

endpackage

// File: rtl/irq_hp_active.sv
module irq_hp_active #(
   parameter int BANK_W    = 32,
   parameter int NUM_BANKS = 2,
   localparam int TOT      = BANK_W * NUM_BANKS
) (
   input  logic [TOT-1:0] pend_i,
   input  logic [TOT-1:0] mask_i,
   input  logic [TOT-1:0] steer_i,
   output logic [TOT-1:0] act_fast_o,
   output logic [TOT-1:0] act_norm_o
);

   // One slice per bank keeps the bank boundary explicit
   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic [BANK_W-1:0] live;
      assign live = pend_i[b*BANK_W +: BANK_W] & mask_i[b*BANK_W +: BANK_W];
      assign act_fast_o[b*BANK_W +: BANK_W] = live &  steer_i[b*BANK_W +: BANK_W];
      assign act_norm_o[b*BANK_W +: BANK_W] = live & ~steer_i[b*BANK_W +: BANK_W];
   end

endmodule

// File: rtl/irq_hp_slot.sv
module irq_hp_slot
   import irq_hp_pkg::*;
#(
   parameter int ENTRY_W = 32,
   parameter int VLD_BIT = 31,
   parameter int NUM_SRC = 40,
   parameter int TOT     = 64
) (
   input  logic [ENTRY_W-1:0] entry_i,
   input  logic [TOT-1:0]     act_fast_i,
   input  logic [TOT-1:0]     act_norm_i,
   output logic               hit_fast_o,
   output logic               hit_norm_o,
   output logic [HP_ID_W-1:0] id_o
);

   logic [HP_ID_W-1:0] src_id;
   logic               usable;
   logic               unused_entry;

   assign src_id = entry_i[HP_ID_W-1:0];
   assign usable = entry_i[VLD_BIT] && (int'(src_id) < NUM_SRC);

   // Bits outside the enable and ID are don't-care
   assign unused_entry = ^entry_i;

   assign hit_fast_o = usable && act_fast_i[src_id];
   assign hit_norm_o = usable && act_norm_i[src_id];
   assign id_o       = src_id;

endmodule

// File: rtl/irq_hp_pick.sv
module irq_hp_pick
   import irq_hp_pkg::*;
#(
   parameter int N      = 40,
   parameter bit ONEHOT = 1'b1
) (
   input  logic [N-1:0]         hit_i,
   input  logic [N*HP_ID_W-1:0] id_i,
   output hp_win_t              win_o
);

   assign win_o.vld = |hit_i;

   if (ONEHOT) begin : g_onehot
      // Isolate the lowest set hit, then OR the selected IDs together
      logic [N-1:0]       first;
      logic [HP_ID_W-1:0] sel;
      assign first = hit_i & (~hit_i + N'(1));
      always_comb begin
         sel = '0;
         for (int i = 0; i < N; i++) begin
            if (first[i]) sel = sel | id_i[i*HP_ID_W +: HP_ID_W];
         end
      end
      assign win_o.id = sel;
   end else begin : g_scan
      // Walk from the highest slot down so the lowest hit is written last
      logic [HP_ID_W-1:0] sel;
      always_comb begin
         sel = '0;
         for (int i = N - 1; i >= 0; i--) begin
            if (hit_i[i]) sel = id_i[i*HP_ID_W +: HP_ID_W];
         end
      end
      assign win_o.id = sel;
   end

endmodule

// File: rtl/irq_hp_resolver.sv
module irq_hp_resolver
   import irq_hp_pkg::*;
#(
   parameter int NUM_SLOTS  = 40,
   parameter int NUM_SRC    = 40,
   parameter int BANK_W     = 32,
   parameter int ENTRY_W    = 32,
   parameter int VLD_BIT    = 31,
   parameter bit REGISTERED = 1'b1,
   parameter bit PICK_ONEHOT = 1'b1,
   localparam int TOT       = 2 * BANK_W
) (
   input  logic                         clk_i,
   input  logic                         rst_ni,
   input  logic [BANK_W-1:0]            pend_b0_i,
   input  logic [BANK_W-1:0]            pend_b1_i,
   input  logic [BANK_W-1:0]            mask_b0_i,
   input  logic [BANK_W-1:0]            mask_b1_i,
   input  logic [BANK_W-1:0]            steer_b0_i,
   input  logic [BANK_W-1:0]            steer_b1_i,
   input  logic [NUM_SLOTS*ENTRY_W-1:0] prio_tab_i,
   output logic [HP_WORD_W-1:0]         hp_word_o
);

   // Elaboration-time parameter checks
   if (NUM_SRC > TOT) begin : g_err_src
      $error("irq_hp_resolver: NUM_SRC exceeds the two banks");
   end
   if (NUM_SRC > 63) begin : g_err_sentinel
      $error("irq_hp_resolver: NUM_SRC must stay below the sentinel ID");
   end
   if (VLD_BIT < HP_ID_W || VLD_BIT >= ENTRY_W) begin : g_err_vld
      $error("irq_hp_resolver: VLD_BIT overlaps the ID or lies outside the slot");
   end
   if (TOT != (1 << HP_ID_W)) begin : g_err_idx
      $error("irq_hp_resolver: two banks must span exactly the ID range");
   end

   logic [TOT-1:0]               act_fast;
   logic [TOT-1:0]               act_norm;
   logic [NUM_SLOTS-1:0]         hit_fast;
   logic [NUM_SLOTS-1:0]         hit_norm;
   logic [NUM_SLOTS*HP_ID_W-1:0] slot_ids;
   hp_win_t                      win_fast;
   hp_win_t                      win_norm;
   logic [HP_WORD_W-1:0]         word_next;

   irq_hp_active #(.BANK_W(BANK_W), .NUM_BANKS(2)) u_active (
      .pend_i    ({pend_b1_i,  pend_b0_i}),
      .mask_i    ({mask_b1_i,  mask_b0_i}),
      .steer_i   ({steer_b1_i, steer_b0_i}),
      .act_fast_o(act_fast),
      .act_norm_o(act_norm)
   );

   for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
      irq_hp_slot #(
         .ENTRY_W(ENTRY_W), .VLD_BIT(VLD_BIT), .NUM_SRC(NUM_SRC), .TOT(TOT)
      ) u_slot (
         .entry_i   (prio_tab_i[s*ENTRY_W +: ENTRY_W]),
         .act_fast_i(act_fast),
         .act_norm_i(act_norm),
         .hit_fast_o(hit_fast[s]),
         .hit_norm_o(hit_norm[s]),
         .id_o      (slot_ids[s*HP_ID_W +: HP_ID_W])
      );
   end

   irq_hp_pick #(.N(NUM_SLOTS), .ONEHOT(PICK_ONEHOT)) u_pick_fast (
      .hit_i(hit_fast),
      .id_i (slot_ids),
      .win_o(win_fast)
   );

   irq_hp_pick #(.N(NUM_SLOTS), .ONEHOT(PICK_ONEHOT)) u_pick_norm (
      .hit_i(hit_norm),
      .id_i (slot_ids),
      .win_o(win_norm)
   );

   assign word_next = hp_pack(win_fast, win_norm);

   if (REGISTERED) begin : g_reg
      logic [HP_WORD_W-1:0] word_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) word_q <= HP_IDLE_WORD;
         else         word_q <= word_next;
      end
      assign hp_word_o = word_q;
   end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk_i ^ rst_ni;
      assign hp_word_o  = word_next;
   end

endmodule

// File: rtl/irq_hp_resolver_chk.sv
module irq_hp_resolver_chk #(
   parameter int NUM_SRC    = 40,
   parameter int BANK_W     = 32,
   parameter bit REGISTERED = 1'b1,
   localparam int TOT       = 2 * BANK_W
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic [BANK_W-1:0] pend_b0_i,
   input logic [BANK_W-1:0] pend_b1_i,
   input logic [BANK_W-1:0] mask_b0_i,
   input logic [BANK_W-1:0] mask_b1_i,
   input logic [BANK_W-1:0] steer_b0_i,
   input logic [BANK_W-1:0] steer_b1_i,
   input logic [31:0]       hp_word_o
);

   logic [TOT-1:0] live;
   logic [TOT-1:0] cur_fast;
   logic [TOT-1:0] cur_norm;
   logic [TOT-1:0] ref_fast;
   logic [TOT-1:0] ref_norm;

   assign live     = {pend_b1_i, pend_b0_i} & {mask_b1_i, mask_b0_i};
   assign cur_fast = live &  {steer_b1_i, steer_b0_i};
   assign cur_norm = live & ~{steer_b1_i, steer_b0_i};

   if (REGISTERED) begin : g_ref_reg
      logic [TOT-1:0] f_q;
      logic [TOT-1:0] n_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            f_q <= '0;
            n_q <= '0;
         end else begin
            f_q <= cur_fast;
            n_q <= cur_norm;
         end
      end
      assign ref_fast = f_q;
      assign ref_norm = n_q;
   end else begin : g_ref_comb
      assign ref_fast = cur_fast;
      assign ref_norm = cur_norm;
   end

   // R9
   rsv_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hp_word_o[30:22] == '0) && (hp_word_o[14:6] == '0));

   // R8
   fast_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !hp_word_o[15] |-> (hp_word_o[5:0] == 6'h3F));

   // R8
   norm_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !hp_word_o[31] |-> (hp_word_o[21:16] == 6'h3F));

   // R4
   fast_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hp_word_o[15] |-> (ref_fast[hp_word_o[5:0]] && (int'(hp_word_o[5:0]) < NUM_SRC)));

   // R5
   norm_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hp_word_o[31] |-> (ref_norm[hp_word_o[21:16]] && (int'(hp_word_o[21:16]) < NUM_SRC)));

   // R2
   fast_none_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ref_fast == '0) |-> !hp_word_o[15]);

   // R2
   norm_none_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ref_norm == '0) |-> !hp_word_o[31]);

endmodule

bind irq_hp_resolver irq_hp_resolver_chk #(
   .NUM_SRC   (NUM_SRC),
   .BANK_W    (BANK_W),
   .REGISTERED(REGISTERED)
) u_chk (
   .clk_i     (clk_i),
   .rst_ni    (rst_ni),
   .pend_b0_i (pend_b0_i),
   .pend_b1_i (pend_b1_i),
   .mask_b0_i (mask_b0_i),
   .mask_b1_i (mask_b1_i),
   .steer_b0_i(steer_b0_i),
   .steer_b1_i(steer_b1_i),
   .hp_word_o (hp_word_o)
);

// File: tb/irq_hp_resolver_bench.sv
module irq_hp_resolver_bench;

   localparam int SLOTS = 40;

   logic          clk = 1'b0;
   logic          rst_ni = 1'b0;
   logic [31:0]   pend0 = '0, pend1 = '0, mask0 = '0, mask1 = '0, steer0 = '0, steer1 = '0;
   logic [31:0]   tab [SLOTS];
   logic [SLOTS*32-1:0] tab_vec;
   logic [31:0]   hp_word;
   int            n_chk = 0;
   int            n_bad = 0;
   bit            done = 1'b0;

   always #5 clk = ~clk;

   always_comb begin
      for (int i = 0; i < SLOTS; i++) tab_vec[i*32 +: 32] = tab[i];
   end

   irq_hp_resolver u_irq_hp_resolver (
      .clk_i     (clk),
      .rst_ni    (rst_ni),
      .pend_b0_i (pend0),
      .pend_b1_i (pend1),
      .mask_b0_i (mask0),
      .mask_b1_i (mask1),
      .steer_b0_i(steer0),
      .steer_b1_i(steer1),
      .prio_tab_i(tab_vec),
      .hp_word_o (hp_word)
   );

   // Behavioural reference: walk the table from slot 0, keep the first match per field
   function automatic logic [31:0] model();
      int fast_id = -1;
      int norm_id = -1;
      logic [31:0] w;
      for (int i = 0; i < SLOTS; i++) begin
         int id = int'(tab[i][5:0]);
         if (tab[i][31] && id < 40) begin
            logic p, m, s;
            if (id >= 32) begin
               p = pend1[id-32]; m = mask1[id-32]; s = steer1[id-32];
            end else begin
               p = pend0[id]; m = mask0[id]; s = steer0[id];
            end
            if (p && m && s && fast_id < 0) fast_id = id;
            if (p && m && !s && norm_id < 0) norm_id = id;
         end
      end
      w = 32'h003F_003F;
      if (fast_id >= 0) begin w[15] = 1'b1; w[5:0] = 6'(fast_id); end
      if (norm_id >= 0) begin w[31] = 1'b1; w[21:16] = 6'(norm_id); end
      return w;
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %08h expected %08h", req, act, exp);
      end
   endtask

   // Inputs are already set; one edge later the word must match the model
   task automatic cycle(string req);
      @(posedge clk);
      @(negedge clk);
      check(req, hp_word, model());
   endtask

   task automatic clear_all();
      pend0 = '0; pend1 = '0; mask0 = '0; mask1 = '0; steer0 = '0; steer1 = '0;
   endtask

   task automatic set_src(int id, bit p, bit m, bit s);
      if (id >= 32) begin
         pend1[id-32] = p; mask1[id-32] = m; steer1[id-32] = s;
      end else begin
         pend0[id] = p; mask0[id] = m; steer0[id] = s;
      end
   endtask

   initial begin
      for (int i = 0; i < SLOTS; i++) tab[i] = 32'h8000_0000 | i;
      // R10: reset value
      @(negedge clk);
      check("R10", hp_word, 32'h003F_003F);
      pend0 = '1; mask0 = '1;
      @(negedge clk);
      check("R10", hp_word, 32'h003F_003F);
      clear_all();
      rst_ni = 1'b1;
      // R8: nothing active
      cycle("R8");
      check("R8", hp_word, 32'h003F_003F);

      // R4, R6 / R5, R7 / R2: each source alone through the identity table
      for (int id = 0; id < 40; id++) begin
         clear_all(); set_src(id, 1, 1, 1);
         cycle(id >= 32 ? "R2" : "R4");
         check("R6", hp_word, 32'h003F_8000 | id);
         clear_all(); set_src(id, 1, 1, 0);
         cycle(id >= 32 ? "R2" : "R5");
         check("R7", hp_word, 32'h8000_003F | (id << 16));
         clear_all(); set_src(id, 1, 0, 1);
         cycle("R2");
         check("R2", hp_word, 32'h003F_003F);
      end

      // R4 and R5 together: one source per field
      clear_all(); set_src(3, 1, 1, 1); set_src(35, 1, 1, 0);
      cycle("R4");
      check("R5", hp_word, 32'h8023_8003);

      // R1: disabled slots are skipped
      pend0 = '1; pend1 = '1; mask0 = '1; mask1 = '1; steer0 = 32'h0F0F_0F0F; steer1 = '0;
      for (int i = 0; i < SLOTS; i++) tab[i] = i;
      cycle("R1");
      check("R1", hp_word, 32'h003F_003F);
      // R1: enabled slots with IDs 40..63 are skipped
      for (int i = 0; i < SLOTS; i++) tab[i] = 32'h8000_0000 | (40 + (i % 24));
      cycle("R1");
      check("R1", hp_word, 32'h003F_003F);
      // R1: don't-care bits do not disturb the slot
      for (int i = 0; i < SLOTS; i++) tab[i] = 32'h7FFF_FFC0 | 63;
      tab[10] = 32'hFFFF_FFC0 | 6'd12;
      tab[11] = 32'hABCD_1200 | 6'd4;
      steer0 = 32'h0000_0010;
      cycle("R1");
      check("R1", hp_word, 32'h800C_8004);

      // R3: reversed order, lowest slot holds the highest ID
      for (int i = 0; i < SLOTS; i++) tab[i] = 32'h8000_0000 | (39 - i);
      pend0 = '1; pend1 = '1; mask0 = '1; mask1 = '1; steer0 = 32'h5555_5555; steer1 = 32'h0000_0055;
      cycle("R3");
      check("R3", hp_word, 32'h8027_8026);
      // R3: duplicate IDs, first matching slot wins
      for (int i = 0; i < SLOTS; i++) tab[i] = 32'h8000_0007;
      tab[0] = 32'h0000_0002;
      tab[5] = 32'h8000_0021;
      tab[6] = 32'h8000_0009;
      clear_all(); set_src(7, 1, 1, 0); set_src(33, 1, 1, 1); set_src(9, 1, 1, 1); set_src(2, 1, 1, 1);
      cycle("R3");
      check("R3", hp_word, 32'h8007_8021);

      // R9 and R3: random tables and vectors
      for (int k = 0; k < 300; k++) begin
         for (int i = 0; i < SLOTS; i++) tab[i] = $urandom;
         pend0 = $urandom; pend1 = $urandom; mask0 = $urandom | $urandom;
         mask1 = $urandom | $urandom; steer0 = $urandom; steer1 = $urandom;
         cycle("R3");
         check("R9", hp_word & 32'h7FC0_7FC0, 32'h0);
      end

      // R10: the word holds until the next edge
      for (int k = 0; k < 8; k++) begin
         logic [31:0] prev;
         prev = hp_word;
         for (int i = 0; i < SLOTS; i++) tab[i] = 32'h8000_0000 | ((i + k * 5) % 40);
         pend0 = $urandom; pend1 = $urandom; mask0 = '1; mask1 = '1; steer0 = $urandom; steer1 = $urandom;
         #1;
         check("R10", hp_word, prev);
         cycle("R10");
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      #1_000_000;
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

endmodule